// File: doc/BRIEF.md
# Gated Three-Bit One-Of-Eight Line Selector

This block turns a three-bit binary code into a single active line out of eight. The outputs are active low. The line whose index equals the code is pulled to 0, and the other seven stay at 1. A typical use is picking one of eight peripherals, banks or strobes from an address field.

Three enable inputs of mixed polarity gate the decode. One enable is active high, and two are active low. The decode runs only when the high enable is 1 and both low enables are 0. Under any other enable pattern, all eight outputs are forced high, whatever the code.

The block has no clock and no storage. Its outputs follow its inputs combinationally.

Top module: `line_sel8`

## Requirements
- R1: The code `sel` is three bits wide, with `sel[2]` as the most significant bit. With the block enabled, code 3'b011 drives only `lineN[3]` low, and code 3'b111 drives only `lineN[7]` low.
- R2: With the block enabled, exactly one bit of `lineN` is 0 for every code value, and that bit's index equals `sel`.
- R3: The outputs are active low. The selected bit reads 0, and each of the other seven bits reads 1.
- R4: When `enPos` is 0, `lineN` is 8'hFF for every code value and every state of the other enables.
- R5: When `enNegA` is 1, `lineN` is 8'hFF for every code value and every state of the other enables.
- R6: When `enNegB` is 1, `lineN` is 8'hFF for every code value and every state of the other enables.
- R7: The block is purely combinational. A change on `sel` or on any enable shows on `lineN` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 3 | Binary code of the line to select; bit 2 is the MSB |
| enPos | input | 1 | Active-high enable; must be 1 for the decode to run |
| enNegA | input | 1 | First active-low enable; must be 0 for the decode to run |
| enNegB | input | 1 | Second active-low enable; must be 0 for the decode to run |
| lineN | output | 8 | Active-low one-of-eight outputs; bit i is low when line i is selected |

## Verification
The only internal state is the single decode-on strobe that the enable logic hands to the output stage. If that strobe is wrong, one of two things shows on `lineN` for the same input pattern. Either all eight lines stay high while the block should be enabled, or one line goes low while some enable is off. If the per-line comparison is wrong, the fault shows at once as a missing low bit, a second low bit, or a low bit at the wrong index. The bench applies all eight codes under all eight enable patterns, so each such fault is exposed by the first input pattern that reaches it.

// File: rtl/line_sel8_pkg.sv
package line_sel8_pkg;

  localparam int SEL_W = 3;
  localparam int OUT_N = 1 << SEL_W;

  // Strobes handed from the enable logic to the output stage
  typedef struct packed {
    logic decodeOn;
  } selStrobe_t;

endpackage

// File: rtl/line_sel8_ctrl.sv
module line_sel8_ctrl
  import line_sel8_pkg::*;
(
  input  logic       enPos,
  input  logic       enNegA,
  input  logic       enNegB,
  output selStrobe_t strb
);

  logic posOk;
  logic negOk;

  always_comb begin
    posOk = enPos;
    negOk = !(enNegA || enNegB);
    strb.decodeOn = posOk && negOk;
  end

endmodule

// File: rtl/line_sel8_dp.sv
module line_sel8_dp
  import line_sel8_pkg::*;
#(
  parameter int SW = SEL_W,
  localparam int ON = 1 << SW
) (
  input  logic [SW-1:0] sel,
  input  selStrobe_t    strb,
  output logic [ON-1:0] lineN
);

  for (genvar i = 0; i < ON; i++) begin : g_line
    assign lineN[i] = !(strb.decodeOn && (sel == SW'(i)));
  end

  always_comb begin
    if (strb.decodeOn) begin
      AST_ONE_LOW: assert ($countones(~lineN) == 1); // R2
    end else begin
      AST_IDLE_HIGH: assert (&lineN); // R4
    end
  end

endmodule

// File: rtl/line_sel8.sv
module line_sel8
  import line_sel8_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             enPos,
  input  logic             enNegA,
  input  logic             enNegB,
  output logic [OUT_N-1:0] lineN
);

  selStrobe_t strb;

  line_sel8_ctrl u_ctrl (
    .enPos  (enPos),
    .enNegA (enNegA),
    .enNegB (enNegB),
    .strb   (strb)
  );

  line_sel8_dp #(.SW(SEL_W)) u_dp (
    .sel   (sel),
    .strb  (strb),
    .lineN (lineN)
  );

  always_comb begin
    if (!enPos) begin
      AST_POS_OFF: assert (lineN == '1); // R4
    end
    if (enNegA) begin
      AST_NEGA_OFF: assert (lineN == '1); // R5
    end
    if (enNegB) begin
      AST_NEGB_OFF: assert (lineN == '1); // R6
    end
    if (enPos && !enNegA && !enNegB) begin
      AST_SEL_LOW: assert (lineN[sel] == 1'b0); // R3
    end
  end

endmodule

// File: tb/line_sel8_test.sv
module line_sel8_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = '0;
  logic       enPos = 1'b0;
  logic       enNegA = 1'b1;
  logic       enNegB = 1'b1;
  logic [7:0] lineN;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  line_sel8 uut (
    .sel    (sel),
    .enPos  (enPos),
    .enNegA (enNegA),
    .enNegB (enNegB),
    .lineN  (lineN)
  );

  function automatic logic [7:0] model(logic [2:0] s, logic p, logic a, logic b);
    if (p && !a && !b) return ~(8'b1 << s);
    return 8'hFF;
  endfunction

  function automatic string tagOf(logic [2:0] s, logic p, logic a, logic b);
    if (!p) return "R4";
    if (a) return "R5";
    if (b) return "R6";
    if (s == 3'd3 || s == 3'd7) return "R1";
    return "R2 R3";
  endfunction

  task automatic check(logic [7:0] exp, string tag);
    checks++;
    if (lineN !== exp) begin
      fails++;
      $display("FAIL %s: lineN=%b expected=%b", tag, lineN, exp);
    end
  endtask

  task automatic applyVec(logic [2:0] s, logic p, logic a, logic b);
    item_t it;
    @(posedge clk);
    sel = s; enPos = p; enNegA = a; enNegB = b;
    it.exp = model(s, p, a, b);
    it.tag = tagOf(s, p, a, b);
    q.push_back(it);
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.exp, it.tag);
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check(8'hFF, "R4 reset-state");
    rst = 1'b0;
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        applyVec(3'(s), e[2], e[1], e[0]);
      end
    end
    repeat (3) @(posedge clk);
    // R7: change inputs between edges and look without any clock edge
    @(negedge clk);
    #1;
    sel = 3'd5; enPos = 1'b1; enNegA = 1'b0; enNegB = 1'b0;
    #1;
    check(8'b1101_1111, "R7 sel change");
    enNegB = 1'b1;
    #1;
    check(8'hFF, "R7 enable change");
    enNegB = 1'b0; sel = 3'd0;
    #1;
    check(8'b1111_1110, "R7 code 0");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule